// File: doc/BRIEF.md
# Configuration Context Cache Controller

This controller decides which array configurations sit in the context slots of a reconfigurable coprocessor. The processor issues a configure command that carries a function number. The controller holds up to four configurations in local slots, and at most one slot is active at a time. If the requested function is already in a slot, that slot becomes active at once. If it is not, the controller picks a slot to overwrite and asks an external loader for the configuration. The processor stays stalled until the loader reports completion.

The processor can also start a multi-cycle array operation by giving a cycle count. The controller loads a down-counter with that count and keeps the stall asserted until the count runs out. Any command that arrives while the stall is high is dropped. Function numbers outside the loadable range are refused with a one-cycle error pulse.

Top module: `ccc_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `load_req`, `stall`, `active_valid` and `cfg_err` are all 0.
- R2: A configure command whose function number is 14 or greater makes `cfg_err` 1 for exactly the next cycle. It raises no `load_req` and leaves `active_valid` and `active_id` unchanged.
- R3: A configure command whose function is held in a slot sets `active_id` to that function and `active_slot` to that slot on the next cycle. `load_req` and `stall` both stay 0.
- R4: A configure command whose function is not held sets `load_req` and `stall` on the next cycle, with `load_id` equal to the requested function. The request and its `load_id` and `load_slot` stay unchanged until `load_done` is sampled high.
- R5: On the cycle after `load_done` is sampled with `load_req` high, `load_req` and `stall` are 0, `active_id` equals the loaded function, and `active_slot` equals the slot that was loaded. A later configure command for that function is then a hit.
- R6: While any slot is empty, a miss loads the empty slot with the lowest index, counting from 0 to 3.
- R7: When all four slots are full, a miss replaces the least recently activated slot. The active slot is never chosen.
- R8: An operation start accepted with count N keeps `stall` at 1 for exactly N cycles, starting on the next cycle. A count of 0 behaves like a count of 1.
- R9: Configure and operation-start commands sampled while `stall` is 1 are ignored. If a configure command and an operation start arrive together, the configure command is taken and the operation start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_req | input | 1 | Configure command strobe |
| cfg_id | input | ID_W | Function number for the configure command |
| op_start | input | 1 | Start a multi-cycle array operation |
| op_cycles | input | CNT_W | Length of the operation in cycles |
| load_done | input | 1 | Loader has finished writing the requested configuration |
| load_req | output | 1 | Request to the loader |
| load_id | output | ID_W | Function to be loaded |
| load_slot | output | SLOT_W | Slot that receives the configuration |
| stall | output | 1 | Hold the processor |
| active_valid | output | 1 | A configuration is active |
| active_id | output | ID_W | Function in the active slot |
| active_slot | output | SLOT_W | Index of the active slot |
| cfg_err | output | 1 | One-cycle pulse for a refused function number |

## Verification
The hardest state to reach from the ports is replacement with a full cache. It needs all four slots filled and a known recency order, and only then does a miss show the victim choice. The stimulus fills the slots in a fixed order and then runs a long arithmetic sequence of function numbers that mixes hits and misses. A bench-side model of the slots with timestamps predicts each victim. Commands dropped during a stall are provoked by pulsing a configure command in the middle of a load and in the middle of an operation, and then checking `load_id`, `load_req` and `active_id` afterwards.

// File: rtl/ccc_pkg.sv
// Shared types for the configuration context cache controller.
package ccc_pkg;
    // Controller state: idle (accepting commands) or waiting on a load.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ccc_state_e;
endpackage

// File: rtl/ccc_tag_store.sv
// Tag store for the context slots.
// What it does: holds the function tag and valid bit of each slot, finds a
// hit for a lookup, keeps a recency age per slot (0 = most recent), and
// names the replacement slot.
// Victim rule: the lowest-index empty slot first; otherwise the oldest slot
// that is not the protected (active) slot.
// Assumes: ages start as a permutation and are only touched one slot per cycle.
module ccc_tag_store #(
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   lookup_id,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [ID_W-1:0]   fill_id,
    input  logic              touch_en,
    input  logic [SLOT_W-1:0] touch_slot,
    input  logic              keep_valid,
    input  logic [SLOT_W-1:0] keep_slot,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [SLOT_W-1:0] victim_slot
);
    logic [ID_W-1:0]   tag_q [NUM_SLOTS];
    logic [SLOT_W-1:0] age_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] vld_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Per-slot tag, valid and recency age update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
                age_q[g] <= SLOT_W'(g);
            end else begin
                if (fill_en && fill_slot == SLOT_W'(g)) begin
                    vld_q[g] <= 1'b1;
                    tag_q[g] <= fill_id;
                end
                if (touch_en) begin
                    if (touch_slot == SLOT_W'(g)) begin
                        age_q[g] <= '0;
                    end else if (age_q[g] < age_q[touch_slot]) begin
                        age_q[g] <= age_q[g] + 1'b1;
                    end
                end
            end
        end
    end

    // Associative lookup of the requested function.
    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!hit && vld_q[i] && tag_q[i] == lookup_id) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(i);
            end
        end
    end

    // Replacement choice: an empty slot first, then the oldest unprotected slot.
    always_comb begin
        logic              found;
        logic              have;
        logic [SLOT_W-1:0] best_age;
        found       = 1'b0;
        have        = 1'b0;
        best_age    = '0;
        victim_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!found && !vld_q[i]) begin
                found       = 1'b1;
                victim_slot = SLOT_W'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (!(keep_valid && keep_slot == SLOT_W'(i)) &&
                    (!have || age_q[i] > best_age)) begin
                    have        = 1'b1;
                    best_age    = age_q[i];
                    victim_slot = SLOT_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/ccc_op_timer.sv
// Operation cycle counter.
// What it does: loads a count at operation start and counts down to zero;
// busy is high while the count is nonzero. A start count of 0 loads 1.
// Assumes: start is only given when busy is low.
module ccc_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (cycles == '0) ? CNT_W'(1) : cycles;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ccc_ctrl.sv
// Configuration context cache controller (top).
// What it does: takes configure and operation-start commands from the
// processor. On a hit it switches the active slot; on a miss it requests a
// load into the chosen victim slot; it refuses out-of-range function numbers;
// and it stalls the processor during loads and multi-cycle operations.
// Assumes: the loader holds the slot contents; load_done is a single-cycle
// pulse given while load_req is high.
module ccc_ctrl
    import ccc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_FUNCS = 14,
    parameter int ID_W      = 4,
    parameter int CNT_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              op_start,
    input  logic [CNT_W-1:0]  op_cycles,
    input  logic              load_done,
    output logic              load_req,
    output logic [ID_W-1:0]   load_id,
    output logic [SLOT_W-1:0] load_slot,
    output logic              stall,
    output logic              active_valid,
    output logic [ID_W-1:0]   active_id,
    output logic [SLOT_W-1:0] active_slot,
    output logic              cfg_err
);
    ccc_state_e        st_q;
    logic [ID_W-1:0]   pend_id_q;
    logic [SLOT_W-1:0] pend_slot_q;
    logic [ID_W-1:0]   act_id_q;
    logic [SLOT_W-1:0] act_slot_q;
    logic              act_valid_q;
    logic              err_q;
    logic              busy;
    logic              tag_hit;
    logic [SLOT_W-1:0] hit_slot;
    logic [SLOT_W-1:0] victim_slot;
    logic              cfg_go;
    logic              op_go;
    logic              bad_id;
    logic              fill_en;
    logic              touch_en;

    assign stall    = (st_q == ST_LOAD) || busy;
    assign cfg_go   = cfg_req && !stall;
    assign op_go    = op_start && !stall && !cfg_req;
    assign bad_id   = (cfg_id >= ID_W'(NUM_FUNCS));
    assign fill_en  = (st_q == ST_LOAD) && load_done;
    assign touch_en = fill_en || (cfg_go && !bad_id && tag_hit);

    ccc_tag_store #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lookup_id   (cfg_id),
        .fill_en     (fill_en),
        .fill_slot   (pend_slot_q),
        .fill_id     (pend_id_q),
        .touch_en    (touch_en),
        .touch_slot  (fill_en ? pend_slot_q : hit_slot),
        .keep_valid  (act_valid_q),
        .keep_slot   (act_slot_q),
        .hit         (tag_hit),
        .hit_slot    (hit_slot),
        .victim_slot (victim_slot)
    );

    ccc_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (op_go),
        .cycles (op_cycles),
        .busy   (busy)
    );

    // Command sequencing: hit switch, miss load, error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pend_id_q   <= '0;
            pend_slot_q <= '0;
            act_id_q    <= '0;
            act_slot_q  <= '0;
            act_valid_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            err_q <= cfg_go && bad_id;
            case (st_q)
                ST_IDLE: begin
                    if (cfg_go && !bad_id) begin
                        if (tag_hit) begin
                            act_slot_q  <= hit_slot;
                            act_id_q    <= cfg_id;
                            act_valid_q <= 1'b1;
                        end else begin
                            st_q        <= ST_LOAD;
                            pend_id_q   <= cfg_id;
                            pend_slot_q <= victim_slot;
                        end
                    end
                end
                ST_LOAD: begin
                    if (load_done) begin
                        st_q        <= ST_IDLE;
                        act_slot_q  <= pend_slot_q;
                        act_id_q    <= pend_id_q;
                        act_valid_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign load_req     = (st_q == ST_LOAD);
    assign load_id      = pend_id_q;
    assign load_slot    = pend_slot_q;
    assign active_valid = act_valid_q;
    assign active_id    = act_id_q;
    assign active_slot  = act_slot_q;
    assign cfg_err      = err_q;
endmodule

// File: rtl/ccc_checker.sv
// Assertion checker for ccc_ctrl, attached by bind.
// What it does: checks the command, load and stall relations over time.
// Assumes: the reset is synchronous and active low.
module ccc_checker #(
    parameter int NUM_FUNCS = 14,
    parameter int ID_W      = 4,
    parameter int CNT_W     = 8,
    parameter int SLOT_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req,
    input logic [ID_W-1:0]   cfg_id,
    input logic              op_start,
    input logic [CNT_W-1:0]  op_cycles,
    input logic              load_done,
    input logic              load_req,
    input logic [ID_W-1:0]   load_id,
    input logic [SLOT_W-1:0] load_slot,
    input logic              stall,
    input logic              active_valid,
    input logic [ID_W-1:0]   active_id,
    input logic [SLOT_W-1:0] active_slot,
    input logic              cfg_err,
    input logic              tag_hit
);
    logic ok_id;
    assign ok_id = (cfg_id < ID_W'(NUM_FUNCS));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!load_req && !stall && !active_valid && !cfg_err));

    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !stall && !ok_id) |=> (cfg_err && !load_req && $stable(active_id)));

    a_r3_hit_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !stall && ok_id && tag_hit) |=>
        (active_valid && active_id == $past(cfg_id) && !load_req && !stall));

    a_r4_miss_request: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !stall && ok_id && !tag_hit) |=>
        (load_req && stall && load_id == $past(cfg_id)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_done) |=> (load_req && $stable(load_id) && $stable(load_slot)));

    a_r4_stall_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> stall);

    a_r5_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_done) |=>
        (!load_req && !stall && active_valid && active_id == $past(load_id) &&
         active_slot == $past(load_slot)));

    a_r7_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && active_valid) |-> (load_slot != active_slot));

    a_r8_op_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !cfg_req && !stall) |=> stall);

    a_r9_drop_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !load_req) |=> (!load_req && $stable(active_id)));
endmodule

bind ccc_ctrl ccc_checker #(
    .NUM_FUNCS (NUM_FUNCS),
    .ID_W      (ID_W),
    .CNT_W     (CNT_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_req      (cfg_req),
    .cfg_id       (cfg_id),
    .op_start     (op_start),
    .op_cycles    (op_cycles),
    .load_done    (load_done),
    .load_req     (load_req),
    .load_id      (load_id),
    .load_slot    (load_slot),
    .stall        (stall),
    .active_valid (active_valid),
    .active_id    (active_id),
    .active_slot  (active_slot),
    .cfg_err      (cfg_err),
    .tag_hit      (tag_hit)
);

// File: tb/sim_ccc_ctrl.sv
// Self-checking bench for ccc_ctrl. A slot model with timestamps predicts
// hits, victims and active state. Inputs are driven on the falling edge and
// outputs are sampled on the falling edge after the rising edge.
module sim_ccc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_req = 1'b0;
    logic [3:0] cfg_id = '0;
    logic       op_start = 1'b0;
    logic [7:0] op_cycles = '0;
    logic       load_done = 1'b0;
    logic       load_req;
    logic [3:0] load_id;
    logic [1:0] load_slot;
    logic       stall;
    logic       active_valid;
    logic [3:0] active_id;
    logic [1:0] active_slot;
    logic       cfg_err;

    int nchk = 0;
    int nfail = 0;

    int m_tag [4];
    bit m_val [4];
    int m_last [4];
    int m_act = 0;
    bit m_actv = 1'b0;
    int tnow = 0;

    always #10 clk = ~clk;

    ccc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_id(cfg_id),
        .op_start(op_start), .op_cycles(op_cycles), .load_done(load_done),
        .load_req(load_req), .load_id(load_id), .load_slot(load_slot),
        .stall(stall), .active_valid(active_valid), .active_id(active_id),
        .active_slot(active_slot), .cfg_err(cfg_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int m_find(int id);
        for (int i = 0; i < 4; i++) if (m_val[i] && m_tag[i] == id) return i;
        return -1;
    endfunction

    function automatic bit m_full();
        for (int i = 0; i < 4; i++) if (!m_val[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_victim();
        int best;
        best = -1;
        for (int i = 0; i < 4; i++) if (!m_val[i]) return i;
        for (int i = 0; i < 4; i++)
            if (!(m_actv && i == m_act) && (best < 0 || m_last[i] < m_last[best])) best = i;
        return best;
    endfunction

    task automatic m_touch(int s);
        tnow++;
        m_last[s] = tnow;
        m_act = s;
        m_actv = 1'b1;
    endtask

    task automatic check_active(string req);
        chk(req, "active_valid", int'(active_valid), int'(m_actv));
        if (m_actv) begin
            chk(req, "active_id", int'(active_id), m_tag[m_act]);
            chk(req, "active_slot", int'(active_slot), m_act);
        end
    endtask

    // One configure command with full checking of its outcome.
    task automatic do_cfg(int id);
        int s;
        int v;
        @(negedge clk);
        cfg_req = 1'b1;
        cfg_id = 4'(id);
        @(negedge clk);
        cfg_req = 1'b0;
        if (id >= 14) begin
            chk("R2", "cfg_err", int'(cfg_err), 1);
            chk("R2", "load_req", int'(load_req), 0);
            check_active("R2");
            @(negedge clk);
            chk("R2", "cfg_err drop", int'(cfg_err), 0);
            chk("R2", "load_req later", int'(load_req), 0);
        end else begin
            s = m_find(id);
            if (s >= 0) begin
                chk("R3", "load_req", int'(load_req), 0);
                chk("R3", "stall", int'(stall), 0);
                m_touch(s);
                check_active("R3");
            end else begin
                v = m_victim();
                chk("R4", "load_req", int'(load_req), 1);
                chk("R4", "stall", int'(stall), 1);
                chk("R4", "load_id", int'(load_id), id);
                if (m_full()) chk("R7", "victim", int'(load_slot), v);
                else chk("R6", "victim", int'(load_slot), v);
                // A configure command during the load must be dropped (R9).
                cfg_req = 1'b1;
                cfg_id = 4'((id + 7) % 14);
                @(negedge clk);
                cfg_req = 1'b0;
                @(negedge clk);
                chk("R9", "load_id kept", int'(load_id), id);
                chk("R4", "load_req held", int'(load_req), 1);
                load_done = 1'b1;
                @(negedge clk);
                load_done = 1'b0;
                m_tag[v] = id;
                m_val[v] = 1'b1;
                m_touch(v);
                chk("R5", "load_req", int'(load_req), 0);
                chk("R5", "stall", int'(stall), 0);
                check_active("R5");
            end
        end
    endtask

    // One operation of length n, optionally poking a configure mid-way.
    task automatic do_op(int n, bit poke);
        int cnt;
        int exp;
        int spare;
        spare = 0;
        for (int i = 0; i < 14; i++) if (m_find(i) < 0) spare = i;
        exp = (n == 0) ? 1 : n;
        @(negedge clk);
        op_start = 1'b1;
        op_cycles = 8'(n);
        @(negedge clk);
        op_start = 1'b0;
        cnt = 0;
        while (stall && cnt < 1000) begin
            cnt++;
            if (poke && cnt == 2) begin
                cfg_req = 1'b1;
                cfg_id = 4'(spare);
                op_start = 1'b1;
            end
            @(negedge clk);
            cfg_req = 1'b0;
            op_start = 1'b0;
        end
        chk("R8", "stall cycles", cnt, exp);
        if (poke) begin
            chk("R9", "no load after poke", int'(load_req), 0);
            chk("R9", "stall after poke", int'(stall), 0);
            check_active("R9");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "load_req in reset", int'(load_req), 0);
        chk("R1", "stall in reset", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "load_req", int'(load_req), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "active_valid", int'(active_valid), 0);
        chk("R1", "cfg_err", int'(cfg_err), 0);

        // Refusal before anything is active.
        do_cfg(15);
        // Fill in order, with a hit in between.
        do_cfg(3);
        do_cfg(7);
        do_cfg(3);
        do_cfg(11);
        do_cfg(2);
        do_cfg(7);
        do_cfg(5);
        do_cfg(14);

        // Arithmetic sweep that mixes hits, misses and refusals.
        for (int k = 0; k < 80; k++) begin
            do_cfg((k * k * 3 + k) % 14);
            if (k % 10 == 9) do_cfg(14 + (k / 10) % 2);
        end

        // Operation lengths, including 0, with mid-stall commands from 3 on.
        for (int n = 0; n < 9; n++) do_op(n, n >= 3);

        // Configure and operation start together: the configure wins (R9).
        @(negedge clk);
        cfg_req = 1'b1;
        cfg_id = 4'(m_tag[m_act]);
        op_start = 1'b1;
        op_cycles = 8'd4;
        @(negedge clk);
        cfg_req = 1'b0;
        op_start = 1'b0;
        m_touch(m_act);
        chk("R9", "op dropped", int'(stall), 0);
        check_active("R9");

        // Reload of a recent function after fills is a hit (R5).
        do_cfg(m_tag[m_act]);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule